// File: doc/BRIEF.md
# Virtual Interrupt-Controller Access Router

This block sits beside the address path of a virtualised CPU. It looks at every access aimed at the local interrupt controller and sorts it into one of four routes. Memory accesses arrive after address translation. Model-specific-register (MSR) instructions and CR8 moves come straight from the core.

The four routes are:
- pass the access on to ordinary memory;
- forward it to the real controller;
- redirect it to the task-priority entry of a per-CPU virtual register page;
- raise a virtualization exit with a reason code.

Each CPU context supplies its own access-page base and virtual-page base. Several virtual CPUs can therefore share one access page, while each keeps a private virtual page.

The decision is a single registered stage. One valid request gives one classified result on the next clock edge, with no back-pressure.

Top module: `vapic_access_router`

## Requirements
- R1: While reset is held, and on the first edge after it, `out_valid` and `exit_pulse` are 0.
- R2: A request with `in_valid`=1 produces `out_valid`=1 on the next edge, together with exactly one route: 0 pass, 1 real, 2 redirect, 3 exit. With `in_valid`=0 the next `out_valid` is 0. The source codes are 0 memory, 1 MSR, 2 CR8, and 3 reserved. A reserved source always gives pass with the address unchanged.
- R3: A memory access takes the redirect route when `en_virt_acc`=1, its page (address bits above 11) equals `acc_base_pg`, and its offset (bits 11:0) is 080h. The output address is `{virt_base_pg, 12'h080}`.
- R4: A memory access to the enabled access page at any offset other than 080h gives exit with reason 1, and the output address is 0.
- R5: When `acc_base_pg` equals `real_base_pg` and `en_virt_acc`=1, an access to that page never takes the real route.
- R6: With `en_virt_acc`=0, the access-page base is ignored. Such an access is routed as real if it hits `real_base_pg`, and as pass otherwise.
- R7: A memory access that hits `real_base_pg` (24-bit page field) takes the real route. Any other memory access takes the pass route. In both cases the address is unchanged.
- R8: MSR accesses are classified by index `in_addr`, and the index range 800h–8FFh is handled as follows:
  - With `en_x2`=1, index 808h takes the task-priority path, and any other index in the range exits with reason 3.
  - With `en_x2`=0, an index in the range takes the real route.
  - An index outside the range takes the pass route.
- R9: A CR8 access always takes the task-priority path.
- R10: The task-priority path depends on `en_tpr_shadow`. With `en_tpr_shadow`=1 it gives redirect to `{virt_base_pg, 12'h080}`. With `en_tpr_shadow`=0 it gives exit with reason 2 and address 0.
- R11: `exit_pulse` is high for exactly the cycles in which the route is exit. `exit_reason` is 0 whenever the route is not exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_src | input | 2 | Source: 0 memory, 1 MSR, 2 CR8 |
| in_write | input | 1 | Write (1) or read (0); carried for context, routing is the same for both |
| in_addr | input | PA_W | Physical address, or MSR index |
| real_base_pg | input | PA_W-12 | Page of the real controller window (FEE00h after platform reset) |
| acc_base_pg | input | PA_W-12 | Page of the access page |
| virt_base_pg | input | PA_W-12 | Page of this CPU's virtual register page |
| en_virt_acc | input | 1 | Enable special handling of the access page |
| en_x2 | input | 1 | Enable virtualization of MSR-mode controller registers |
| en_tpr_shadow | input | 1 | Virtual page present |
| out_valid | output | 1 | Classified result present |
| out_route | output | 2 | Route code |
| out_addr | output | PA_W | Address to use (0 on exit) |
| exit_pulse | output | 1 | One-cycle exit strobe |
| exit_reason | output | 2 | 1 bad offset, 2 no virtual page, 3 MSR not virtualised |

## Verification
There is no internal state that lasts beyond one request. Any decoding fault therefore appears at the ports on the edge right after the faulty request.

A wrong priority or a wrong enable gate shows up as a wrong route code in that cycle. A wrong concatenation of the redirect address shows up as a wrong `out_addr`.

The bench compares every cycle against an independent model. It does so under biased random stimulus in which the two bases collide often and the enables toggle.

// File: rtl/vapic_access_router.sv
module vapic_access_router #(
  parameter int PA_W = 36,
  parameter logic [11:0] TPR_OFS = 12'h080,
  parameter logic [11:0] MSR_TPR = 12'h808
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_src,
  input  logic              in_write,
  input  logic [PA_W-1:0]   in_addr,
  input  logic [PA_W-13:0]  real_base_pg,
  input  logic [PA_W-13:0]  acc_base_pg,
  input  logic [PA_W-13:0]  virt_base_pg,
  input  logic              en_virt_acc,
  input  logic              en_x2,
  input  logic              en_tpr_shadow,
  output logic              out_valid,
  output logic [1:0]        out_route,
  output logic [PA_W-1:0]   out_addr,
  output logic              exit_pulse,
  output logic [1:0]        exit_reason
);
  localparam int PG_W = PA_W - 12;
  localparam logic [1:0] RT_PASS = 2'd0, RT_REAL = 2'd1, RT_REDIR = 2'd2, RT_EXIT = 2'd3;
  localparam logic [1:0] EX_NONE = 2'd0, EX_OFS = 2'd1, EX_NOVP = 2'd2, EX_MSR = 2'd3;
  localparam logic [1:0] SRC_MEM = 2'd0, SRC_MSR = 2'd1, SRC_CR8 = 2'd2;

  wire [PG_W-1:0] pg = in_addr[PA_W-1:12];
  wire [11:0] ofs = in_addr[11:0];
  wire hit_acc = en_virt_acc && (pg == acc_base_pg);
  wire hit_real = (pg == real_base_pg);
  wire msr_rng = (pg == '0) && (ofs[11:8] == 4'h8);
  wire [PA_W-1:0] redir_addr = {virt_base_pg, TPR_OFS};
  wire unused_wr = in_write;

  logic want_tpr;
  logic [1:0] route_d, reason_d;
  logic [PA_W-1:0] addr_d;

  always_comb begin
    want_tpr = 1'b0;
    route_d  = RT_PASS;
    reason_d = EX_NONE;
    addr_d   = in_addr;
    unique case (in_src)
      SRC_MEM: begin
        if (hit_acc) begin
          if (ofs == TPR_OFS) want_tpr = 1'b1;
          else begin route_d = RT_EXIT; reason_d = EX_OFS; end
        end else if (hit_real) route_d = RT_REAL;
      end
      SRC_MSR: begin
        if (msr_rng) begin
          if (!en_x2) route_d = RT_REAL;
          else if (ofs == MSR_TPR) want_tpr = 1'b1;
          else begin route_d = RT_EXIT; reason_d = EX_MSR; end
        end
      end
      SRC_CR8: want_tpr = 1'b1;
      default: ;
    endcase
    if (want_tpr) begin
      if (en_tpr_shadow) begin route_d = RT_REDIR; addr_d = redir_addr; end
      else begin route_d = RT_EXIT; reason_d = EX_NOVP; end
    end
    if (route_d == RT_EXIT) addr_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_route   <= RT_PASS;
      out_addr    <= '0;
      exit_pulse  <= 1'b0;
      exit_reason <= EX_NONE;
    end else begin
      out_valid   <= in_valid;
      out_route   <= in_valid ? route_d : RT_PASS;
      out_addr    <= in_valid ? addr_d : '0;
      exit_pulse  <= in_valid && (route_d == RT_EXIT);
      exit_reason <= in_valid ? reason_d : EX_NONE;
    end
  end

  a_r2_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r11_exit_has_reason: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |-> (out_valid && out_route == RT_EXIT && exit_reason != EX_NONE));
  a_r5_acc_beats_real: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_src == SRC_MEM && en_virt_acc && pg == acc_base_pg) |=> (out_route != RT_REAL));
  a_r10_cr8_no_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_src == SRC_CR8 && !en_tpr_shadow) |=> (exit_pulse && exit_reason == EX_NOVP));
  a_r3_redirect_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_route == RT_REDIR) |-> (out_addr[11:0] == TPR_OFS));
endmodule

// File: tb/tb_vapic_access_router.sv
module tb_vapic_access_router;
  localparam int PA_W = 36;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_write = 0, en_virt_acc = 0, en_x2 = 0, en_tpr_shadow = 0;
  logic [1:0] in_src = 0;
  logic [PA_W-1:0] in_addr = 0;
  logic [23:0] real_base_pg = 24'hFEE00, acc_base_pg = 24'h00ABC, virt_base_pg = 24'h12345;
  logic out_valid, exit_pulse;
  logic [1:0] out_route, exit_reason;
  logic [PA_W-1:0] out_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vapic_access_router #(.PA_W(PA_W)) dut (.*);

  int e_route, e_reason;
  logic [PA_W-1:0] e_addr;
  string e_tag;

  task automatic model();
    longint pg = in_addr >> 12;
    int ofs = int'(in_addr & 36'hFFF);
    bit tpr = 0;
    e_route = 0; e_reason = 0; e_addr = in_addr; e_tag = "R7";
    if (in_src == 2'd0) begin
      if (en_virt_acc && pg == acc_base_pg) begin
        if (ofs == 'h80) tpr = 1;
        else begin e_route = 3; e_reason = 1; e_tag = "R4"; end
        if (acc_base_pg == real_base_pg) e_tag = "R5";
      end else if (pg == real_base_pg) begin
        e_route = 1; e_tag = (acc_base_pg == real_base_pg) ? "R6" : "R7";
      end
    end else if (in_src == 2'd1) begin
      e_tag = "R8";
      if (in_addr >= 'h800 && in_addr <= 'h8FF) begin
        if (!en_x2) e_route = 1;
        else if (in_addr == 'h808) tpr = 1;
        else begin e_route = 3; e_reason = 3; end
      end
    end else if (in_src == 2'd2) begin
      tpr = 1; e_tag = "R9";
    end else e_tag = "R2";
    if (tpr) begin
      if (en_tpr_shadow) begin
        e_route = 2; e_addr = {virt_base_pg, 12'h080};
        if (in_src == 2'd0 && e_tag != "R5") e_tag = "R3";
      end else begin e_route = 3; e_reason = 2; e_tag = "R10"; end
    end
    if (e_route == 3) e_addr = '0;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step_and_check();
    bit v = in_valid;
    model();
    @(negedge clk);
    chk("R2", out_valid, v, "out_valid");
    if (v) begin
      chk(e_tag, out_route, e_route, "route");
      chk(e_tag, out_addr, e_addr, "addr");
      chk("R11", exit_pulse, e_route == 3, "exit_pulse");
      chk("R11", exit_reason, e_reason, "exit_reason");
    end else chk("R11", exit_pulse, 0, "exit_pulse idle");
  endtask

  task automatic req(logic [1:0] s, logic [PA_W-1:0] a, bit w);
    in_valid = 1; in_src = s; in_addr = a; in_write = w;
    step_and_check();
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", out_valid, 0, "out_valid in reset");
    chk("R1", exit_pulse, 0, "exit_pulse in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", out_valid, 0, "out_valid after reset");
    en_virt_acc = 1; en_x2 = 1; en_tpr_shadow = 1;
    req(2'd0, {acc_base_pg, 12'h080}, 0);   // R3
    req(2'd0, {acc_base_pg, 12'h0B0}, 1);   // R4
    req(2'd0, {real_base_pg, 12'h020}, 0);  // R7 real
    req(2'd0, 36'h0_5555_5010, 1);          // R7 pass
    req(2'd1, 36'h808, 1);                  // R8 tpr
    req(2'd1, 36'h80B, 1);                  // R8 exit
    req(2'd1, 36'hC0000080, 0);             // R8 out of range
    req(2'd2, 36'h0, 1);                    // R9
    req(2'd3, {acc_base_pg, 12'h080}, 0);   // R2 reserved
    en_x2 = 0;
    req(2'd1, 36'h808, 0);                  // R8 disabled -> real
    en_tpr_shadow = 0;
    req(2'd2, 36'h0, 0);                    // R10
    req(2'd0, {acc_base_pg, 12'h080}, 0);   // R10
    en_tpr_shadow = 1;
    acc_base_pg = real_base_pg;
    req(2'd0, {real_base_pg, 12'h080}, 0);  // R5
    req(2'd0, {real_base_pg, 12'h300}, 0);  // R5
    en_virt_acc = 0;
    req(2'd0, {real_base_pg, 12'h080}, 0);  // R6
    in_valid = 0;
    step_and_check();                       // R2 idle
    for (int i = 0; i < 4000; i++) begin
      logic [23:0] p;
      logic [11:0] o;
      int k = $urandom_range(0, 3);
      if (i % 50 == 0) begin
        en_virt_acc = 1'($urandom); en_x2 = 1'($urandom); en_tpr_shadow = 1'($urandom);
        acc_base_pg = ($urandom_range(0, 1) != 0) ? real_base_pg : 24'(24'h00A00 + $urandom_range(0, 3));
        virt_base_pg = 24'($urandom);
      end
      p = (k == 0) ? acc_base_pg : (k == 1) ? real_base_pg : 24'($urandom_range(0, 2));
      o = ($urandom_range(0, 2) == 0) ? 12'h080 : 12'($urandom);
      in_valid = ($urandom_range(0, 7) != 0);
      in_src = 2'($urandom);
      in_write = 1'($urandom);
      if (in_src == 2'd1)
        in_addr = ($urandom_range(0, 3) == 0) ? 36'h808 : {24'h0, 4'h8, o[7:0]} + 36'($urandom_range(0, 1) << 9);
      else in_addr = {p, o};
      step_and_check();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule